// File: doc/BRIEF.md
# Segmented LED Driver Streamer

This block feeds a chain of grayscale LED drivers that take their data in 9-bit bit-plane order: the top bit of every LED first, then the next lower bit, down to bit 0. Each multiplexed column gets exactly one grayscale clock segment of 512 cycles. The grayscale clock runs without a break for the whole segment. Inside the segment, 72 leading cycles carry no serial clock. Nine 48-bit words then follow, with one idle serial-clock cycle after every word except the last. A write latch command ends each of the first eight words. The display latch command ends exactly on the segment's final cycle.

The block works from three inputs. A frame buffer hands over data through a request/data handshake: the streamer raises its request only in cycles that carry a serial bit, so blanking never consumes a data word. A stream-ready level starts operation. A position pulse marks each new slice. After eight columns the block idles until the position pulse arrives. A position pulse that arrives while a slice is being sent lets the current column finish in full; the next slice then starts at column 0 with no gap. The serial and grayscale clocks are not generated here. The block produces clock-enable outputs that an external clock gate uses.

Top module: `seg_streamer`

## Requirements
- R1: After reset, and for as long as the stream-ready input has never been high, the outputs gclk_en_o, sclk_en_o, lat_o, col_done_o and fb_req_o stay low. A position pulse in this state has no effect.
- R2: Each column occupies exactly SEG_LEN (512) consecutive cycles with gclk_en_o high. Segments within a slice follow each other with no low cycle in between.
- R3: During the first 72 cycles of a segment, sclk_en_o and lat_o are low and no frame-buffer request is made.
- R4: After the blanking, a segment carries 9 words of 48 serial bits, with exactly one cycle of sclk_en_o low between consecutive words (432 bits). fb_req_o is high in exactly the cycles whose bit is shifted out one cycle later. In that later cycle, sdo_o shows the fb_data_i value sampled at the request, in request order.
- R5: On each of the first 8 words, lat_o is high for exactly one cycle: the word's last serial cycle. This is the write latch, encoded as 1 latched edge.
- R6: On the final word, lat_o is high for the last 3 serial cycles. This is the display latch, encoded as 3 latched edges. Its last cycle is the segment's 512th cycle.
- R7: col_done_o is high for exactly one cycle: the segment's final cycle. In that cycle col_o gives the column just finished. Within a slice the columns run 0 to 7 in order.
- R8: After column 7, gclk_en_o stays low until a position pulse. A position pulse in that state starts a new slice at column 0.
- R9: A position pulse during sending does not shorten the current column. The segment that follows belongs to column 0 of the next slice and starts with no idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Streamer clock, one cycle per grayscale clock period |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| stream_ready_i | input | 1 | Level: enough slices are buffered to begin |
| pos_sync_i | input | 1 | One-cycle pulse: the display reached the next slice position |
| fb_req_o | output | 1 | Request for one bit per driver chain in this cycle |
| fb_data_i | input | DRIVERS | Frame-buffer data, valid in the cycle fb_req_o is high |
| gclk_en_o | output | 1 | Grayscale clock enable |
| sclk_en_o | output | 1 | Serial clock enable |
| lat_o | output | 1 | Latch command line |
| sdo_o | output | DRIVERS | Serial data, one bit per driver chain |
| col_done_o | output | 1 | One-cycle strobe on a column's final cycle |
| col_o | output | COLW | Index of the column that just finished |

## Verification
The bench builds the block with its default parameters: a 512-cycle segment, 9 planes of 48 bits, 8 columns and two driver chains. With these values the exact 72 + 432 + 8 cycle layout and the eight-column slice wrap are exercised. The bench also exercises both latch lengths and the hand-off from column 7 into the wait state. A position pulse is placed at cycle 200 of column 3, which exercises the early restart into column 0. A further pulse comes before the stream-ready input rises, which exercises the ignored case.

// File: rtl/seg_streamer_pkg.sv
package seg_streamer_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_WAIT = 2'd2
  } strm_state_e;
endpackage

// File: rtl/seg_timer.sv
module seg_timer #(
  parameter int SEG_LEN      = 512,
  parameter int LEAD_BLANK   = 72,
  parameter int WORD_BITS    = 48,
  parameter int WORDS        = 9,
  parameter int WR_LAT_LEN   = 1,
  parameter int DISP_LAT_LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic seg_last,
  output logic data_slot,
  output logic lat_cmd
);
  localparam int CW = $clog2(SEG_LEN);
  localparam int BW = $clog2(WORD_BITS + 1);
  localparam int WW = $clog2(WORDS + 1);

  logic [CW-1:0] cyc_q, cyc_d;
  logic [BW-1:0] bit_q, bit_d;
  logic [WW-1:0] word_q, word_d;
  logic          in_blank, last_word, upd;
  logic [BW-1:0] lat_from;

  assign in_blank  = cyc_q < CW'(LEAD_BLANK);
  assign last_word = word_q == WW'(WORDS - 1);
  assign seg_last  = run && (cyc_q == CW'(SEG_LEN - 1));
  assign data_slot = run && !in_blank && (bit_q < BW'(WORD_BITS));
  assign lat_from  = last_word ? BW'(WORD_BITS - DISP_LAT_LEN) : BW'(WORD_BITS - WR_LAT_LEN);
  assign lat_cmd   = data_slot && (bit_q >= lat_from);
  assign upd       = run || (cyc_q != '0);

  always_comb begin
    cyc_d  = cyc_q;
    bit_d  = bit_q;
    word_d = word_q;
    if (!run || seg_last) begin
      cyc_d  = '0;
      bit_d  = '0;
      word_d = '0;
    end else begin
      cyc_d = cyc_q + 1'b1;
      if (!in_blank) begin
        if (bit_q == BW'(WORD_BITS)) begin
          bit_d  = '0;
          word_d = word_q + 1'b1;
        end else begin
          bit_d = bit_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q  <= '0;
      bit_q  <= '0;
      word_q <= '0;
    end else if (upd) begin
      cyc_q  <= cyc_d;
      bit_q  <= bit_d;
      word_q <= word_d;
    end
  end
endmodule

// File: rtl/slice_seq.sv
module slice_seq
  import seg_streamer_pkg::*;
#(
  parameter int COLS = 8,
  parameter int COLW = $clog2(COLS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            stream_ready,
  input  logic            pos_sync,
  input  logic            seg_last,
  output logic            run,
  output logic [COLW-1:0] col
);
  strm_state_e     state_q, state_d;
  logic [COLW-1:0] col_q, col_d;
  logic            pend_q, pend_d;

  always_comb begin
    state_d = state_q;
    col_d   = col_q;
    pend_d  = pend_q;
    case (state_q)
      ST_IDLE: begin
        if (stream_ready) begin
          state_d = ST_SEND;
          col_d   = '0;
          pend_d  = 1'b0;
        end
      end
      ST_SEND: begin
        if (pos_sync) pend_d = 1'b1;
        if (seg_last) begin
          pend_d = 1'b0;
          if (pend_q || pos_sync) begin
            col_d = '0;
          end else if (col_q == COLW'(COLS - 1)) begin
            state_d = ST_WAIT;
            col_d   = '0;
          end else begin
            col_d = col_q + 1'b1;
          end
        end
      end
      ST_WAIT: begin
        if (pos_sync) begin
          state_d = ST_SEND;
          col_d   = '0;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      col_q   <= '0;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      col_q   <= col_d;
      pend_q  <= pend_d;
    end
  end

  assign run = state_q == ST_SEND;
  assign col = col_q;
endmodule

// File: rtl/drv_out_reg.sv
module drv_out_reg #(
  parameter int DRIVERS = 2,
  parameter int COLW    = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               data_slot,
  input  logic               lat_cmd,
  input  logic               seg_last,
  input  logic [COLW-1:0]    col,
  input  logic [DRIVERS-1:0] fb_data,
  output logic               gclk_en,
  output logic               sclk_en,
  output logic               lat,
  output logic [DRIVERS-1:0] sdo,
  output logic               col_done,
  output logic [COLW-1:0]    col_out
);
  logic [DRIVERS-1:0] sdo_d;
  logic [COLW-1:0]    col_d;

  always_comb begin
    sdo_d = data_slot ? fb_data : '0;
    col_d = seg_last ? col : col_out;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gclk_en  <= 1'b0;
      sclk_en  <= 1'b0;
      lat      <= 1'b0;
      sdo      <= '0;
      col_done <= 1'b0;
      col_out  <= '0;
    end else begin
      gclk_en  <= run;
      sclk_en  <= data_slot;
      lat      <= lat_cmd;
      sdo      <= sdo_d;
      col_done <= seg_last;
      col_out  <= col_d;
    end
  end
endmodule

// File: rtl/seg_streamer.sv
module seg_streamer #(
  parameter int DRIVERS      = 2,
  parameter int COLS         = 8,
  parameter int SEG_LEN      = 512,
  parameter int PLANES       = 9,
  parameter int WORD_BITS    = 48,
  parameter int WR_LAT_LEN   = 1,
  parameter int DISP_LAT_LEN = 3,
  parameter int COLW         = $clog2(COLS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               stream_ready_i,
  input  logic               pos_sync_i,
  output logic               fb_req_o,
  input  logic [DRIVERS-1:0] fb_data_i,
  output logic               gclk_en_o,
  output logic               sclk_en_o,
  output logic               lat_o,
  output logic [DRIVERS-1:0] sdo_o,
  output logic               col_done_o,
  output logic [COLW-1:0]    col_o
);
  localparam int LEAD_BLANK = SEG_LEN - PLANES * WORD_BITS - (PLANES - 1);

  logic [1:0]      rs_q;
  logic            rst_sync_n;
  logic            run, seg_last, data_slot, lat_cmd;
  logic [COLW-1:0] col;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  slice_seq #(.COLS(COLS), .COLW(COLW)) u_seq (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .stream_ready (stream_ready_i),
    .pos_sync     (pos_sync_i),
    .seg_last     (seg_last),
    .run          (run),
    .col          (col)
  );

  seg_timer #(
    .SEG_LEN      (SEG_LEN),
    .LEAD_BLANK   (LEAD_BLANK),
    .WORD_BITS    (WORD_BITS),
    .WORDS        (PLANES),
    .WR_LAT_LEN   (WR_LAT_LEN),
    .DISP_LAT_LEN (DISP_LAT_LEN)
  ) u_tmr (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .run       (run),
    .seg_last  (seg_last),
    .data_slot (data_slot),
    .lat_cmd   (lat_cmd)
  );

  drv_out_reg #(.DRIVERS(DRIVERS), .COLW(COLW)) u_out (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .run       (run),
    .data_slot (data_slot),
    .lat_cmd   (lat_cmd),
    .seg_last  (seg_last),
    .col       (col),
    .fb_data   (fb_data_i),
    .gclk_en   (gclk_en_o),
    .sclk_en   (sclk_en_o),
    .lat       (lat_o),
    .sdo       (sdo_o),
    .col_done  (col_done_o),
    .col_out   (col_o)
  );

  assign fb_req_o = data_slot;
endmodule

// File: rtl/seg_streamer_chk.sv
module seg_streamer_chk #(
  parameter int SEG_LEN    = 512,
  parameter int LEAD_BLANK = 72,
  parameter int COLW       = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            fb_req_o,
  input logic            gclk_en_o,
  input logic            sclk_en_o,
  input logic            lat_o,
  input logic            col_done_o,
  input logic [COLW-1:0] col_o
);
  localparam int CW = $clog2(SEG_LEN) + 1;
  logic [CW-1:0] pos_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        pos_q <= '0;
    else if (!gclk_en_o || col_done_o) pos_q <= '0;
    else                               pos_q <= pos_q + 1'b1;
  end

  AST_QUIET_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    !gclk_en_o |-> (!sclk_en_o && !lat_o && !col_done_o)); // R1
  AST_SEG_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    col_done_o |-> (pos_q == CW'(SEG_LEN - 1))); // R2
  AST_SEG_CONTINUOUS: assert property (@(posedge clk) disable iff (!rst_n)
    (gclk_en_o && !col_done_o) |=> gclk_en_o); // R2
  AST_BLANK_LEAD: assert property (@(posedge clk) disable iff (!rst_n)
    (gclk_en_o && pos_q < CW'(LEAD_BLANK)) |-> !sclk_en_o); // R3
  AST_REQ_LEADS_SCLK: assert property (@(posedge clk) disable iff (!rst_n)
    fb_req_o |=> sclk_en_o); // R4
  AST_LAT_ON_SCLK: assert property (@(posedge clk) disable iff (!rst_n)
    lat_o |-> sclk_en_o); // R5
  AST_DONE_WITH_DISP_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    col_done_o |-> (lat_o && $past(lat_o))); // R6
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    col_done_o |=> !col_done_o); // R7
endmodule

bind seg_streamer seg_streamer_chk #(
  .SEG_LEN    (SEG_LEN),
  .LEAD_BLANK (LEAD_BLANK),
  .COLW       (COLW)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .fb_req_o   (fb_req_o),
  .gclk_en_o  (gclk_en_o),
  .sclk_en_o  (sclk_en_o),
  .lat_o      (lat_o),
  .col_done_o (col_done_o),
  .col_o      (col_o)
);

// File: tb/seg_streamer_bench.sv
module seg_streamer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DRV = 2;
  localparam int CW  = 3;

  logic           clk;
  logic           rst_n;
  logic           stream_ready;
  logic           pos_sync;
  logic           fb_req;
  logic [DRV-1:0] fb_data;
  logic           gclk_en, sclk_en, lat, col_done;
  logic [DRV-1:0] sdo;
  logic [CW-1:0]  col;

  int n_run, n_fail;
  bit finished;

  int nreq, nd, dseg, mp, nseg, gaps;
  int e_blank, e_data, e_wlat, e_dlat, e_len;
  int cols_seen [0:63];
  bit mon_on;

  seg_streamer u_seg_streamer (
    .clk            (clk),
    .rst_n          (rst_n),
    .stream_ready_i (stream_ready),
    .pos_sync_i     (pos_sync),
    .fb_req_o       (fb_req),
    .fb_data_i      (fb_data),
    .gclk_en_o      (gclk_en),
    .sclk_en_o      (sclk_en),
    .lat_o          (lat),
    .sdo_o          (sdo),
    .col_done_o     (col_done),
    .col_o          (col)
  );

  function automatic logic [DRV-1:0] pat(int n);
    return DRV'((n ^ (n >> 3) ^ (n >> 6)) & 3);
  endfunction

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk) if (fb_req) nreq <= nreq + 1;
  assign fb_data = pat(nreq);

  // Layout monitor: expected values derived from R2..R7
  always @(negedge clk) begin
    if (mon_on) begin
      if (gclk_en) begin
        if (mp < 72) begin
          if (sclk_en || lat) e_blank++;
        end else begin
          int w, b;
          bit xs, xl;
          w  = (mp - 72) / 49;
          b  = (mp - 72) % 49;
          xs = (b != 48);
          xl = xs && ((w < 8) ? (b == 47) : (b >= 45));
          if (sclk_en !== xs) e_data++;
          if (xs) begin
            if (sdo !== pat(nd)) e_data++;
            nd++;
            dseg++;
          end
          if (lat !== xl) begin
            if (w < 8) e_wlat++;
            else       e_dlat++;
          end
        end
        if (col_done) begin
          if (mp != 511) e_len++;
          if (dseg != 432) e_data++;
          cols_seen[nseg % 64] = int'(col);
          nseg++;
          mp   = 0;
          dseg = 0;
        end else begin
          mp++;
          if (mp > 511) e_len++;
        end
      end else begin
        if (mp != 0) e_len++;
        if (sclk_en || lat || col_done) e_blank++;
        gaps++;
      end
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic pulse_pos();
    @(negedge clk);
    pos_sync = 1'b1;
    @(negedge clk);
    pos_sync = 1'b0;
  endtask

  task automatic wait_segs(int target);
    int guard;
    guard = 0;
    while (nseg < target && guard < 20000) begin
      tick();
      guard++;
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    stream_ready = 1'b0;
    pos_sync = 1'b0;
    repeat (3) tick();
    check(gclk_en == 1'b0, "R1 gclk_en in reset", int'(gclk_en), 0);
    check(sclk_en == 1'b0 && lat == 1'b0, "R1 sclk_en/lat in reset", int'({sclk_en, lat}), 0);
    check(col_done == 1'b0, "R1 col_done in reset", int'(col_done), 0);
    check(fb_req == 1'b0, "R1 fb_req in reset", int'(fb_req), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) tick();
    mon_on = 1'b1;
  endtask

  task automatic t_idle_ignore();
    int seen;
    seen = 0;
    pulse_pos();
    repeat (30) begin
      tick();
      if (gclk_en || fb_req) seen++;
    end
    check(seen == 0, "R1 pos_sync before stream_ready", seen, 0);
  endtask

  task automatic t_first_slice();
    int bad;
    @(negedge clk);
    stream_ready = 1'b1;
    wait_segs(8);
    tick();
    bad = 0;
    for (int i = 0; i < 8; i++) if (cols_seen[i] != i) bad++;
    check(nseg == 8, "R7 columns per slice", nseg, 8);
    check(bad == 0, "R7 column order 0..7", bad, 0);
    check(e_len == 0, "R2 segment length/continuity errors", e_len, 0);
    check(e_blank == 0, "R3 activity in blanking", e_blank, 0);
    check(e_data == 0, "R4 data layout errors", e_data, 0);
    check(nd == 8 * 432, "R4 serial bits in slice", nd, 8 * 432);
    check(nreq == nd, "R4 requests equal shifted bits", nreq, nd);
    check(e_wlat == 0, "R5 write latch errors", e_wlat, 0);
    check(e_dlat == 0, "R6 display latch errors", e_dlat, 0);
  endtask

  task automatic t_wait();
    int hi;
    hi = 0;
    repeat (100) begin
      tick();
      if (gclk_en) hi++;
    end
    check(hi == 0, "R8 idle after column 7", hi, 0);
    check(nseg == 8, "R8 no column while waiting", nseg, 8);
  endtask

  task automatic t_restart();
    pulse_pos();
    wait_segs(9);
    check(cols_seen[8] == 0, "R8 restart column", cols_seen[8], 0);
    check(e_len == 0, "R2 restart segment length", e_len, 0);
  endtask

  task automatic t_midsend();
    wait_segs(11);
    check(cols_seen[10] == 2, "R7 column before early pulse", cols_seen[10], 2);
    repeat (200) @(negedge clk);
    pulse_pos();
    wait_segs(12);
    check(cols_seen[11] == 3, "R9 current column finished", cols_seen[11], 3);
    tick();
    check(gclk_en == 1'b1, "R9 no gap before next slice", int'(gclk_en), 1);
    wait_segs(13);
    check(cols_seen[12] == 0, "R9 next slice starts at column 0", cols_seen[12], 0);
    check(e_len == 0, "R9 early pulse keeps full segment", e_len, 0);
    check(e_data == 0 && e_wlat == 0 && e_dlat == 0, "R4 layout after early pulse",
          e_data + e_wlat + e_dlat, 0);
    check(nreq == nd, "R4 requests after early pulse", nreq, nd);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    finish_run();
  end

  initial begin
    n_run = 0; n_fail = 0; finished = 1'b0;
    nreq = 0; nd = 0; dseg = 0; mp = 0; nseg = 0; gaps = 0;
    e_blank = 0; e_data = 0; e_wlat = 0; e_dlat = 0; e_len = 0;
    mon_on = 1'b0;
    for (int i = 0; i < 64; i++) cols_seen[i] = -1;
    t_reset();
    t_idle_ignore();
    t_first_slice();
    t_wait();
    t_restart();
    t_midsend();
    finish_run();
  end
endmodule